// File: doc/BRIEF.md
# Polyphase Halfband Decimate-by-Two Filter

This block halves the sample rate of a real signed sample stream with a halfband FIR filter. It computes only the outputs that survive decimation. Accepted samples are split by index parity. Even-indexed samples fill an even-coefficient branch. Odd-indexed samples fill a short delay line, and that branch reduces to a single product with the centre coefficient, because every other odd-indexed tap of a halfband filter is zero. Each decimated output is the sum of the two branches. The sum goes through a selectable rounding and saturation stage and leaves as a 16-bit word with a valid strobe.

A control FSM tracks the phase of the input stream. It has three states. `PH_PRIME` counts accepted samples while the delay lines fill. It moves to `PH_WANT_ODD` when sample index 2·NUM_EVEN−2 is accepted, and that acceptance also launches the first output. `PH_WANT_EVEN` moves to `PH_WANT_ODD` on an accepted sample, which is even-indexed and launches an output. `PH_WANT_ODD` moves back to `PH_WANT_EVEN` on an accepted sample, which is odd-indexed and only enters the odd delay line. When `in_valid` is low, no state changes.

Coefficients are in signed Q1.15 format. They are captured from the coefficient ports in any cycle in which `coef_load` is high, and they are not affected by reset. With the default NUM_EVEN = 4, the prototype has 7 taps, C0 to C6. The centre tap is C3.

Top module: `hb_decim2`

## Requirements
- R1: A synchronous reset drives `out_valid` and `out_data` to 0 by the next cycle. It clears both delay lines and the phase FSM, so the first sample accepted after reset is index 0.
- R2: With 7 taps, output k equals the sum over i = 0..6 of x[2k+i]·C[i], scaled by 2^-15. C[2j] is taken from `coef_even[16j+15:16j]`, C3 from `coef_center`, and C1 and C5 are zero.
- R3: `out_valid` is high for exactly one cycle, in the cycle after each accepted even-indexed sample whose index is 6 or more, and at no other time. A run of N ≥ 7 samples therefore yields (N−7)/2+1 outputs, using integer division.
- R4: A cycle with `in_valid` low does not shift either delay line, does not advance the phase, and produces no output.
- R5: `rnd_sel` selects the number of kept most-significant bits: codes 0 to 4 keep 8 to 12 bits, code 5 keeps 14 bits and code 6 keeps all 16. The kept field sits at the top of `out_data`, and the bits below it are zero.
- R6: Rounding adds one half of the kept LSB to the full-precision sum and then takes the floor, so an exact half rounds toward positive infinity.
- R7: A rounded value outside the kept signed range is clamped to the largest or smallest value of that range. It never wraps.
- R8: Code 7 gives an all-zero `out_data` on every output, while `out_valid` keeps its normal cadence.
- R9: Coefficients change only in a cycle with `coef_load` high. Changes on the coefficient ports at any other time have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| coef_load | input | 1 | Capture the coefficient ports this cycle |
| coef_even | input | NUM_EVEN*COEF_W | Even-indexed coefficients, C[2j] in slice j |
| coef_center | input | COEF_W | Centre coefficient |
| rnd_sel | input | 3 | Output precision code |
| in_valid | input | 1 | Input sample qualifier |
| in_data | input | DATA_W | Signed input sample |
| out_valid | output | 1 | Decimated output strobe |
| out_data | output | 16 | Rounded, saturated output word |

## Verification
Every output is checked against a direct transversal convolution of the accepted samples that keeps every second result, under all eight rounding codes:
- **Parity errors.** A design that pairs samples with the wrong parity, or takes the wrong odd sample as the centre term, fails on the first output.
- **Idle cycles.** Runs with idle cycles inserted catch a delay line or phase tracker that advances without `in_valid`, which would show up as shifted results or outputs at the wrong time.
- **Mid-stream reset.** A reset on an odd phase catches a phase tracker that does not restart.
- **Saturation and rounding.** Full-scale inputs with full-scale coefficients catch wrap-around in place of clamping. An isolated exact half catches truncation in place of round-half-up.
- **Ignored coefficient changes.** Changing the coefficient ports without `coef_load` catches coefficients that are used directly from the ports instead of from the loaded registers.

// File: rtl/hb_decim2_pkg.sv
package hb_decim2_pkg;

    localparam int OUT_W = 16;

    typedef enum logic [1:0] {
        PH_PRIME,
        PH_WANT_EVEN,
        PH_WANT_ODD
    } phase_t;

    // Kept precision for a rounding code; 0 means the word is forced to zero.
    function automatic int kept_bits(input logic [2:0] code);
        int n;
        case (code)
            3'd0, 3'd1, 3'd2, 3'd3, 3'd4: n = 8 + int'(code);
            3'd5:                         n = 14;
            3'd6:                         n = OUT_W;
            default:                      n = 0;
        endcase
        return n;
    endfunction

    // Bits of the output word that must read zero for a rounding code.
    function automatic logic [OUT_W-1:0] low_mask(input logic [2:0] code);
        logic [OUT_W-1:0] one;
        one = 1;
        if (kept_bits(code) == 0)
            return '1;
        return (one << (OUT_W - kept_bits(code))) - one;
    endfunction

endpackage

// File: rtl/hb_decim2_phase.sv
module hb_decim2_phase
    import hb_decim2_pkg::*;
#(
    parameter int NUM_EVEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    output logic take_even,
    output logic take_odd,
    output logic emit
);

    localparam int LAST  = 2 * NUM_EVEN - 2;
    localparam int CNT_W = $clog2(LAST + 1);

    phase_t             st, st_nx;
    logic [CNT_W-1:0]   cnt, cnt_nx;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= PH_PRIME;
            cnt <= '0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
        end
    end

    always_comb begin
        st_nx  = st;
        cnt_nx = cnt;
        unique case (st)
            PH_PRIME: begin
                if (in_valid) begin
                    if (cnt == CNT_W'(LAST))
                        st_nx = PH_WANT_ODD;
                    else
                        cnt_nx = cnt + 1'b1;
                end
            end
            PH_WANT_EVEN: if (in_valid) st_nx = PH_WANT_ODD;
            PH_WANT_ODD:  if (in_valid) st_nx = PH_WANT_EVEN;
            default:      st_nx = PH_PRIME;
        endcase
    end

    always_comb begin
        take_even = 1'b0;
        take_odd  = 1'b0;
        emit      = 1'b0;
        unique case (st)
            PH_PRIME: begin
                take_even = in_valid && !cnt[0];
                take_odd  = in_valid &&  cnt[0];
                emit      = in_valid && (cnt == CNT_W'(LAST));
            end
            PH_WANT_EVEN: begin
                take_even = in_valid;
                emit      = in_valid;
            end
            PH_WANT_ODD:  take_odd = in_valid;
            default: ;
        endcase
    end

endmodule

// File: rtl/hb_decim2_taps.sv
module hb_decim2_taps #(
    parameter int DATA_W   = 16,
    parameter int COEF_W   = 16,
    parameter int NUM_EVEN = 4,
    parameter int ACC_W    = 35
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          coef_load,
    input  logic [NUM_EVEN*COEF_W-1:0]    coef_even,
    input  logic [COEF_W-1:0]             coef_center,
    input  logic                          take_even,
    input  logic                          take_odd,
    input  logic signed [DATA_W-1:0]      in_data,
    output logic signed [ACC_W-1:0]       acc
);

    localparam int EV_D   = NUM_EVEN - 1;
    localparam int OD_D   = NUM_EVEN / 2;
    localparam int PROD_W = DATA_W + COEF_W;
    localparam int NPROD  = NUM_EVEN + 1;

    logic signed [COEF_W-1:0] ce [NUM_EVEN];
    logic signed [COEF_W-1:0] cc;
    logic signed [DATA_W-1:0] ev [EV_D];
    logic signed [DATA_W-1:0] od [OD_D];
    logic signed [DATA_W-1:0] win [NUM_EVEN];
    logic signed [PROD_W-1:0] prod [NPROD];

    always_ff @(posedge clk) begin
        if (coef_load) begin
            for (int j = 0; j < NUM_EVEN; j++)
                ce[j] <= coef_even[j*COEF_W +: COEF_W];
            cc <= coef_center;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < EV_D; i++) ev[i] <= '0;
            for (int i = 0; i < OD_D; i++) od[i] <= '0;
        end else begin
            if (take_even) begin
                ev[0] <= in_data;
                for (int i = 1; i < EV_D; i++) ev[i] <= ev[i-1];
            end
            if (take_odd) begin
                od[0] <= in_data;
                for (int i = 1; i < OD_D; i++) od[i] <= od[i-1];
            end
        end
    end

    // Even window: age 0 is the arriving sample, older ones from the line.
    assign win[0] = in_data;
    for (genvar a = 1; a < NUM_EVEN; a++) begin : g_win
        assign win[a] = ev[a-1];
    end

    // C[2j] weights the sample of age NUM_EVEN-1-j.
    for (genvar j = 0; j < NUM_EVEN; j++) begin : g_even_mul
        assign prod[j] = PROD_W'(win[NUM_EVEN-1-j]) * PROD_W'(ce[j]);
    end
    assign prod[NUM_EVEN] = PROD_W'(od[OD_D-1]) * PROD_W'(cc);

    always_comb begin
        acc = '0;
        for (int i = 0; i < NPROD; i++)
            acc = acc + ACC_W'(prod[i]);
    end

endmodule

// File: rtl/hb_decim2_round.sv
module hb_decim2_round
    import hb_decim2_pkg::*;
#(
    parameter int ACC_W = 35,
    parameter int FRAC  = 15
) (
    input  logic signed [ACC_W-1:0] acc,
    input  logic [2:0]              rnd_sel,
    output logic [OUT_W-1:0]        word
);

    localparam int SW = ACC_W + 1;

    logic signed [SW-1:0] one, ext, biased, q, maxv, minv;
    logic [OUT_W-1:0]     trunc;
    int                   n, sh;

    always_comb begin
        one    = 1;
        n      = kept_bits(rnd_sel);
        sh     = FRAC + OUT_W - n;
        ext    = SW'(acc);
        biased = '0;
        q      = '0;
        maxv   = '0;
        minv   = '0;
        trunc  = '0;
        word   = '0;
        if (n != 0) begin
            biased = ext + (one <<< (sh - 1));
            q      = biased >>> sh;
            maxv   = (one <<< (n - 1)) - one;
            minv   = -(one <<< (n - 1));
            if (q > maxv)
                q = maxv;
            else if (q < minv)
                q = minv;
            trunc = OUT_W'(q);
            word  = trunc << (OUT_W - n);
        end
    end

endmodule

// File: rtl/hb_decim2.sv
module hb_decim2
    import hb_decim2_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int COEF_W   = 16,
    parameter int NUM_EVEN = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       coef_load,
    input  logic [NUM_EVEN*COEF_W-1:0] coef_even,
    input  logic [COEF_W-1:0]          coef_center,
    input  logic [2:0]                 rnd_sel,
    input  logic                       in_valid,
    input  logic [DATA_W-1:0]          in_data,
    output logic                       out_valid,
    output logic [OUT_W-1:0]           out_data
);

    localparam int ACC_W = DATA_W + COEF_W + $clog2(NUM_EVEN + 1);
    localparam int FRAC  = COEF_W - 1;

    logic                    take_even, take_odd, emit;
    logic signed [ACC_W-1:0] acc;
    logic [OUT_W-1:0]        word;

    hb_decim2_phase #(.NUM_EVEN(NUM_EVEN)) u_phase (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .take_even (take_even),
        .take_odd  (take_odd),
        .emit      (emit)
    );

    hb_decim2_taps #(
        .DATA_W   (DATA_W),
        .COEF_W   (COEF_W),
        .NUM_EVEN (NUM_EVEN),
        .ACC_W    (ACC_W)
    ) u_taps (
        .clk         (clk),
        .rst         (rst),
        .coef_load   (coef_load),
        .coef_even   (coef_even),
        .coef_center (coef_center),
        .take_even   (take_even),
        .take_odd    (take_odd),
        .in_data     (signed'(in_data)),
        .acc         (acc)
    );

    hb_decim2_round #(.ACC_W(ACC_W), .FRAC(FRAC)) u_round (
        .acc     (acc),
        .rnd_sel (rnd_sel),
        .word    (word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= emit;
            if (emit)
                out_data <= word;
        end
    end

endmodule

// File: rtl/hb_decim2_chk.sv
module hb_decim2_chk
    import hb_decim2_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [2:0]       rnd_sel,
    input logic             out_valid,
    input logic [OUT_W-1:0] out_data
);

    logic [2:0] rnd_q;

    always_ff @(posedge clk)
        rnd_q <= rnd_sel;

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (!out_valid && out_data == '0));

    assert_strobe_follows_accept_R3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

    assert_strobe_single_R3: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    assert_idle_no_output_R4: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_low_bits_zero_R5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((out_data & low_mask(rnd_q)) == '0));

    assert_zero_code_R8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && rnd_q == 3'd7) |-> (out_data == '0));

endmodule

bind hb_decim2 hb_decim2_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .rnd_sel   (rnd_sel),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/hb_decim2_bench.sv
module hb_decim2_bench;

    localparam int PERIOD = 10;
    localparam int NE     = 4;
    localparam int TAPS   = 2 * NE - 1;
    localparam int NS     = 20;

    localparam logic signed [15:0] STIM [NS] = '{
        16'sd1200, -16'sd3000, 16'sh7FFF, 16'sh8000, 16'sd77,
        16'sd0, 16'sd15000, -16'sd9999, 16'sd4096, 16'sd1,
        -16'sd1, 16'sd22222, -16'sd18000, 16'sd513, 16'sd8191,
        -16'sd700, 16'sd30000, -16'sd25000, 16'sd123, -16'sd4321
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              coef_load = 1'b0;
    logic [NE*16-1:0]  coef_even = '0;
    logic [15:0]       coef_center = '0;
    logic [2:0]        rnd_sel = 3'd6;
    logic              in_valid = 1'b0;
    logic [15:0]       in_data = '0;
    logic              out_valid;
    logic [15:0]       out_data;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    int                 cur_c [TAPS];
    logic signed [15:0] hist [64];
    int                 n_acc = 0;
    logic               want_out = 1'b0;
    logic               rst_q = 1'b1;
    int                 k = 0;
    logic [15:0]        got [32];
    string              run_tag = "R2";

    always #(PERIOD/2) clk = ~clk;

    hb_decim2 u_hb_decim2 (
        .clk(clk), .rst(rst), .coef_load(coef_load), .coef_even(coef_even),
        .coef_center(coef_center), .rnd_sel(rnd_sel), .in_valid(in_valid),
        .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Transversal reference followed by round-half-up and clamping.
    function automatic logic [15:0] model(input int kk, input logic [2:0] code);
        longint acc = 0;
        longint r, mx, mn;
        int n, sh;
        for (int i = 0; i < TAPS; i++)
            acc += longint'(hist[2*kk+i]) * longint'(cur_c[i]);
        if (code == 3'd7) return 16'h0000;
        n  = (code <= 3'd4) ? 8 + int'(code) : (code == 3'd5 ? 14 : 16);
        sh = 15 + 16 - n;
        r  = (acc + (longint'(1) <<< (sh - 1))) >>> sh;
        mx = (longint'(1) <<< (n - 1)) - 1;
        mn = -(longint'(1) <<< (n - 1));
        if (r > mx) r = mx;
        if (r < mn) r = mn;
        return 16'(r) << (16 - n);
    endfunction

    always @(posedge clk) begin
        rst_q <= rst;
        if (rst) begin
            n_acc    <= 0;
            want_out <= 1'b0;
        end else begin
            want_out <= in_valid && (n_acc >= TAPS - 1) && (n_acc % 2 == 0);
            if (in_valid) begin
                hist[n_acc] <= signed'(in_data);
                n_acc       <= n_acc + 1;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_q) begin
            k = 0;
        end else begin
            check(out_valid === want_out, "R3 strobe timing", longint'(out_valid), longint'(want_out));
            if (out_valid && want_out) begin
                got[k] = out_data;
                check(out_data === model(k, rnd_sel), run_tag, longint'(out_data), longint'(model(k, rnd_sel)));
                k++;
            end
        end
    end

    task automatic load_coefs(input int c0, input int c2, input int c4, input int c6, input int c3);
        @(negedge clk);
        coef_even   = {c6[15:0], c4[15:0], c2[15:0], c0[15:0]};
        coef_center = c3[15:0];
        coef_load   = 1'b1;
        @(negedge clk);
        coef_load = 1'b0;
        cur_c = '{c0, 0, c2, c3, c4, 0, c6};
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);
        check(out_valid === 1'b0 && out_data === 16'h0, "R1 reset state", longint'(out_data), 0);
        rst = 1'b0;
    endtask

    function automatic logic [15:0] stim_val(input int mode, input int i);
        case (mode)
            1: return 16'h7FFF;
            2: return 16'h8000;
            3: return (i == 3) ? 16'h0001 : ((i == 5) ? 16'hFFFF : 16'h0000);
            default: return STIM[i % NS];
        endcase
    endfunction

    task automatic run_seq(input logic [2:0] code, input bit gaps, input int mode, input int nsamp, input string tag);
        do_reset();
        rnd_sel = code;
        run_tag = tag;
        for (int i = 0; i < nsamp; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = stim_val(mode, i);
            if (gaps && (i % 3 == 1)) begin
                @(negedge clk);
                in_valid = 1'b0;
                in_data  = 16'hDEAD;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(k == ((nsamp >= TAPS) ? (nsamp - TAPS) / 2 + 1 : 0), "R3 output count", k,
              (nsamp >= TAPS) ? (nsamp - TAPS) / 2 + 1 : 0);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        load_coefs(-2048, 9216, 9216, -2048, 16384);
        // R2 main function, then every rounding code (R5, R6, R8)
        run_seq(3'd6, 1'b0, 0, NS, "R2 convolution");
        for (int c = 0; c < 8; c++)
            run_seq(3'(c), 1'b0, 0, NS, (c == 7) ? "R8 zero code" : "R5 precision");
        // R4 idle cycles between samples
        run_seq(3'd6, 1'b1, 0, NS, "R4 idle gaps");
        run_seq(3'd3, 1'b1, 0, NS - 1, "R4 idle gaps");
        // R1 mid-stream reset on an odd phase, then a fresh run
        run_seq(3'd6, 1'b0, 0, 11, "R1 partial");
        run_seq(3'd6, 1'b0, 0, NS, "R1 restart");
        // R9 port changes without load are ignored
        @(negedge clk);
        coef_even   = {4{16'h1357}};
        coef_center = 16'h7001;
        run_seq(3'd6, 1'b0, 0, NS, "R9 no load");
        // R7 saturation both ways
        load_coefs(32767, 32767, 32767, 32767, 32767);
        run_seq(3'd6, 1'b0, 1, 9, "R7 positive");
        check(got[0] === 16'h7FFF, "R7 clamp high", longint'(got[0]), 16'h7FFF);
        run_seq(3'd2, 1'b0, 1, 9, "R7 positive");
        check(got[0] === 16'h7FC0, "R7 clamp high 10b", longint'(got[0]), 16'h7FC0);
        run_seq(3'd6, 1'b0, 2, 9, "R7 negative");
        check(got[0] === 16'h8000, "R7 clamp low", longint'(got[0]), 16'h8000);
        // R6 exact halves round upward
        load_coefs(0, 0, 0, 0, 16384);
        run_seq(3'd6, 1'b0, 3, 9, "R6 half up");
        check(got[0] === 16'h0001, "R6 +0.5 rounds to 1", longint'(got[0]), 1);
        check(got[1] === 16'h0000, "R6 -0.5 rounds to 0", longint'(got[1]), 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule